// File: doc/BRIEF.md
# Channel Status Double Buffer

This block holds the channel status bits of a two-channel digital audio transmitter in two register banks of 24 words of 16 bits. The host edits the first bank (the edit buffer) through a plain address/data register port. The serializer reads the second bank (the transmit buffer) through its own word-index read port. Each word carries channel A status in its upper byte and channel B status in its lower byte.

The transmitter asserts a one-cycle block-start pulse at each block boundary of its output timebase. On that pulse the whole edit buffer is copied into the transmit buffer in a single clock edge, so the transmit data never changes in the middle of a block. The host can hold off the copy with an inhibit input while it makes a long series of edits. Each completed copy sets a sticky flag. A status read clears the flag, and the host polls it to find the safe window that opens right after a copy.

Host access works in two modes. In word mode, one access moves a full 16-bit word. In byte mode, each access selects one byte. Writes are dropped when the master clock is reported absent or the block is powered down.

Top module: `cstat_dbuf`

## Requirements
- R1: After reset both banks hold zero everywhere, `copyDone` is 0, and `hostRdData` and `txWord` read 0 at every address and index.
- R2: With `byteMode` = 0, `hostAddr` 0..23 is a word index. A write stores all 16 bits of `hostWrData`, and `hostRdData` returns the whole word. Bits [15:8] are the channel A byte and bits [7:0] the channel B byte.
- R3: With `byteMode` = 1, `hostAddr` 0..47 selects a byte of word `hostAddr`/2. An even address selects bits [15:8] (channel A) and an odd address selects bits [7:0] (channel B). A write stores `hostWrData[7:0]` into that byte only. A read returns the byte in bits [7:0] with bits [15:8] zero.
- R4: A write leaves the edit buffer unchanged while `clkPresent` is 0 or `powerDown` is 1.
- R5: When `blockStart` is 1 and `inhibitCopy` is 0 at a clock edge, the transmit buffer takes the edit buffer contents held before that edge. A host write in the same cycle reaches the edit buffer only.
- R6: While `inhibitCopy` is 1, `blockStart` has no effect and the transmit buffer keeps its contents.
- R7: `copyDone` rises one cycle after each copy and stays at 1 until it is cleared.
- R8: `statusRd` = 1 clears `copyDone` at the next edge, unless a copy happens in the same cycle, in which case it stays 1.
- R9: Host addresses outside the valid range (24..63 in word mode, 48..63 in byte mode) read 0 and writes to them change nothing. A `txIndex` of 24..31 reads 0.
- R10: Host writes never alter `txWord` until the next copy.
- R11: `txWord` returns the transmit buffer word at `txIndex` combinationally. `hostRdData` follows `hostAddr` and `byteMode` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkPresent | input | 1 | Master clock detected; writes are dropped when 0 |
| powerDown | input | 1 | Power-down control; writes are dropped when 1 |
| byteMode | input | 1 | 1 = byte access, 0 = word access |
| hostWrEn | input | 1 | Host write strobe |
| hostAddr | input | 6 | Host word or byte address |
| hostWrData | input | 16 | Host write data (byte mode uses [7:0]) |
| hostRdData | output | 16 | Host read data from the edit buffer |
| statusRd | input | 1 | Host read of the status register; clears the flag |
| copyDone | output | 1 | Sticky copy-complete flag |
| inhibitCopy | input | 1 | Blocks the edit-to-transmit copy |
| blockStart | input | 1 | Block boundary pulse from the transmitter |
| txIndex | input | 5 | Transmit-side word index |
| txWord | output | 16 | Transmit buffer word at `txIndex` |

## Verification
The bound assertions check the following on every cycle:
- a copy reproduces the prior edit contents exactly;
- the transmit bank holds still whenever no copy is granted, including under inhibit;
- gated or absent writes leave the edit bank untouched;
- the flag sets after a copy and clears after a status read that has no competing copy;
- out-of-range transmit indices read 0.

The byte lane mapping of the two host modes, the handling of out-of-range host addresses, and a write colliding with a copy can only be shown by the bench. Its behavioural model reads back every address after directed and pseudo-random traffic.

// File: rtl/cstat_pkg.sv
package cstat_pkg;
  localparam int CS_WORDS  = 24;
  localparam int CS_BYTE_W = 8;
  localparam int CS_WORD_W = 2 * CS_BYTE_W;
  localparam int CS_IDX_W  = $clog2(CS_WORDS);
  localparam int CS_ADDR_W = $clog2(2 * CS_WORDS);

  // Strobes from control to datapath
  typedef struct packed {
    logic                 wrHi;
    logic                 wrLo;
    logic [CS_IDX_W-1:0]  wrIdx;
    logic [CS_BYTE_W-1:0] hiData;
    logic [CS_BYTE_W-1:0] loData;
    logic                 doCopy;
    logic                 rdValid;
    logic                 rdByte;
    logic                 rdHigh;
    logic [CS_IDX_W-1:0]  rdIdx;
  } csStrobe_t;
endpackage

// File: rtl/cstat_ctrl.sv
module cstat_ctrl
  import cstat_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clkPresent,
  input  logic                 powerDown,
  input  logic                 byteMode,
  input  logic                 hostWrEn,
  input  logic [CS_ADDR_W-1:0] hostAddr,
  input  logic [CS_WORD_W-1:0] hostWrData,
  input  logic                 statusRd,
  input  logic                 inhibitCopy,
  input  logic                 blockStart,
  output csStrobe_t            strobe,
  output logic                 copyDone
);
  localparam logic [CS_ADDR_W-1:0] BYTE_LIMIT = CS_ADDR_W'(2 * CS_WORDS);
  localparam logic [CS_ADDR_W-1:0] WORD_LIMIT = CS_ADDR_W'(CS_WORDS);

  logic                wrOpen;
  logic                inRange;
  logic                selHigh;
  logic [CS_IDX_W-1:0] wordIdx;
  logic                copyNow;

  // Address decode for the two access modes
  always_comb begin
    if (byteMode) begin
      inRange = hostAddr < BYTE_LIMIT;
      wordIdx = CS_IDX_W'(hostAddr >> 1);
      selHigh = ~hostAddr[0];
    end else begin
      inRange = hostAddr < WORD_LIMIT;
      wordIdx = CS_IDX_W'(hostAddr);
      selHigh = 1'b1;
    end
  end

  assign wrOpen  = hostWrEn & clkPresent & ~powerDown;
  assign copyNow = blockStart & ~inhibitCopy;

  always_comb begin
    strobe.wrHi    = wrOpen & inRange & (~byteMode | selHigh);
    strobe.wrLo    = wrOpen & inRange & (~byteMode | ~selHigh);
    strobe.wrIdx   = wordIdx;
    strobe.hiData  = byteMode ? hostWrData[CS_BYTE_W-1:0]
                              : hostWrData[CS_WORD_W-1:CS_BYTE_W];
    strobe.loData  = hostWrData[CS_BYTE_W-1:0];
    strobe.doCopy  = copyNow;
    strobe.rdValid = inRange;
    strobe.rdByte  = byteMode;
    strobe.rdHigh  = selHigh;
    strobe.rdIdx   = wordIdx;
  end

  // Sticky completion flag: a copy wins over a clearing read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         copyDone <= 1'b0;
    else if (copyNow)  copyDone <= 1'b1;
    else if (statusRd) copyDone <= 1'b0;
  end
endmodule

// File: rtl/cstat_dpath.sv
module cstat_dpath
  import cstat_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  csStrobe_t                     strobe,
  input  logic [CS_IDX_W-1:0]           txIndex,
  output logic [CS_WORD_W-1:0]          hostRdData,
  output logic [CS_WORD_W-1:0]          txWord,
  output logic [CS_WORDS*CS_WORD_W-1:0] editFlat,
  output logic [CS_WORDS*CS_WORD_W-1:0] txFlat
);
  localparam logic [CS_IDX_W-1:0] IDX_LIMIT = CS_IDX_W'(CS_WORDS);

  for (genvar w = 0; w < CS_WORDS; w++) begin : g_word
    logic [CS_WORD_W-1:0] editQ;
    logic [CS_WORD_W-1:0] txQ;
    logic                 hit;

    assign hit = strobe.wrIdx == CS_IDX_W'(w);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        editQ <= '0;
        txQ   <= '0;
      end else begin
        if (strobe.wrHi && hit) editQ[CS_WORD_W-1:CS_BYTE_W] <= strobe.hiData;
        if (strobe.wrLo && hit) editQ[CS_BYTE_W-1:0]         <= strobe.loData;
        if (strobe.doCopy)      txQ <= editQ;
      end
    end

    assign editFlat[w*CS_WORD_W +: CS_WORD_W] = editQ;
    assign txFlat[w*CS_WORD_W +: CS_WORD_W]   = txQ;
  end

  logic [CS_WORD_W-1:0] hostWord;
  assign hostWord = editFlat[strobe.rdIdx*CS_WORD_W +: CS_WORD_W];

  always_comb begin
    if (!strobe.rdValid)    hostRdData = '0;
    else if (strobe.rdByte) hostRdData = {{CS_BYTE_W{1'b0}},
                                          strobe.rdHigh ? hostWord[CS_WORD_W-1:CS_BYTE_W]
                                                        : hostWord[CS_BYTE_W-1:0]};
    else                    hostRdData = hostWord;
  end

  always_comb begin
    if (txIndex < IDX_LIMIT) txWord = txFlat[txIndex*CS_WORD_W +: CS_WORD_W];
    else                     txWord = '0;
  end
endmodule

// File: rtl/cstat_dbuf.sv
module cstat_dbuf
  import cstat_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clkPresent,
  input  logic                 powerDown,
  input  logic                 byteMode,
  input  logic                 hostWrEn,
  input  logic [CS_ADDR_W-1:0] hostAddr,
  input  logic [CS_WORD_W-1:0] hostWrData,
  output logic [CS_WORD_W-1:0] hostRdData,
  input  logic                 statusRd,
  output logic                 copyDone,
  input  logic                 inhibitCopy,
  input  logic                 blockStart,
  input  logic [CS_IDX_W-1:0]  txIndex,
  output logic [CS_WORD_W-1:0] txWord
);
  csStrobe_t                     strobe;
  logic [CS_WORDS*CS_WORD_W-1:0] editFlat;
  logic [CS_WORDS*CS_WORD_W-1:0] txFlat;

  cstat_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .clkPresent (clkPresent),
    .powerDown  (powerDown),
    .byteMode   (byteMode),
    .hostWrEn   (hostWrEn),
    .hostAddr   (hostAddr),
    .hostWrData (hostWrData),
    .statusRd   (statusRd),
    .inhibitCopy(inhibitCopy),
    .blockStart (blockStart),
    .strobe     (strobe),
    .copyDone   (copyDone)
  );

  cstat_dpath u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .txIndex   (txIndex),
    .hostRdData(hostRdData),
    .txWord    (txWord),
    .editFlat  (editFlat),
    .txFlat    (txFlat)
  );
endmodule

// File: rtl/cstat_dbuf_chk.sv
module cstat_dbuf_chk
  import cstat_pkg::*;
(
  input logic                          clk,
  input logic                          rstN,
  input logic                          clkPresent,
  input logic                          powerDown,
  input logic                          hostWrEn,
  input logic                          statusRd,
  input logic                          copyDone,
  input logic                          inhibitCopy,
  input logic                          blockStart,
  input logic [CS_IDX_W-1:0]           txIndex,
  input logic [CS_WORD_W-1:0]          txWord,
  input logic [CS_WORDS*CS_WORD_W-1:0] editFlat,
  input logic [CS_WORDS*CS_WORD_W-1:0] txFlat
);
  assert_copy_exact_R5: assert property (@(posedge clk) disable iff (!rstN)
    (blockStart && !inhibitCopy) |=> txFlat == $past(editFlat));

  // R6 and R10: no granted copy, no change in the transmit bank
  assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(blockStart && !inhibitCopy) |=> $stable(txFlat));

  assert_write_gated_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!hostWrEn || !clkPresent || powerDown) |=> $stable(editFlat));

  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    (blockStart && !inhibitCopy) |=> copyDone);

  assert_flag_no_spurious_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(blockStart && !inhibitCopy) |=> !$rose(copyDone));

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !(blockStart && !inhibitCopy)) |=> !copyDone);

  assert_tx_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    (txIndex >= CS_IDX_W'(CS_WORDS)) |-> txWord == '0);
endmodule

bind cstat_dbuf cstat_dbuf_chk u_chk (.*);

// File: tb/test_cstat_dbuf.sv
module test_cstat_dbuf;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 24;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clkPresent = 1'b1;
  logic        powerDown = 1'b0;
  logic        byteMode = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [5:0]  hostAddr = '0;
  logic [15:0] hostWrData = '0;
  logic [15:0] hostRdData;
  logic        statusRd = 1'b0;
  logic        copyDone;
  logic        inhibitCopy = 1'b0;
  logic        blockStart = 1'b0;
  logic [4:0]  txIndex = '0;
  logic [15:0] txWord;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  string curReq = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  cstat_dbuf i_cstat_dbuf (.*);

  // Behavioural reference model
  logic [15:0] editRef [WORDS];
  logic [15:0] txRef [WORDS];
  bit          flagRef;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      foreach (editRef[i]) begin editRef[i] = 16'h0; txRef[i] = 16'h0; end
      flagRef = 0;
    end else begin
      bit doCopy;
      doCopy = blockStart && !inhibitCopy;
      if (doCopy) foreach (txRef[i]) txRef[i] = editRef[i];
      if (hostWrEn && clkPresent && !powerDown) begin
        if (byteMode) begin
          if (hostAddr < 48) begin
            if (hostAddr[0]) editRef[hostAddr / 2][7:0]  = hostWrData[7:0];
            else             editRef[hostAddr / 2][15:8] = hostWrData[7:0];
          end
        end else if (hostAddr < WORDS) begin
          editRef[hostAddr] = hostWrData;
        end
      end
      if (doCopy) flagRef = 1;
      else if (statusRd) flagRef = 0;
    end
  end

  function automatic logic [15:0] expRead();
    if (byteMode) begin
      if (hostAddr >= 48) return 16'h0;
      return {8'h0, hostAddr[0] ? editRef[hostAddr / 2][7:0] : editRef[hostAddr / 2][15:8]};
    end
    if (hostAddr >= WORDS) return 16'h0;
    return editRef[hostAddr];
  endfunction

  task automatic check(string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", curReq, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    check("hostRdData", hostRdData, expRead());
    check("txWord", txWord, txIndex < WORDS ? txRef[txIndex] : 16'h0);
    check("copyDone", {15'h0, copyDone}, {15'h0, flagRef});
  endtask

  // One clock: edge, then compare at the falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compareAll();
    hostWrEn = 0; blockStart = 0; statusRd = 0;
  endtask

  task automatic hostWrite(bit bm, int addr, logic [15:0] data);
    byteMode = bm; hostAddr = 6'(addr); hostWrData = data; hostWrEn = 1;
    tick();
  endtask

  task automatic sweepRead(bit bm, int lastAddr);
    for (int a = 0; a <= lastAddr; a++) begin
      byteMode = bm; hostAddr = 6'(a); txIndex = 5'(a % 32);
      #1 compareAll();
    end
  endtask

  task automatic pulseCopy();
    blockStart = 1;
    tick();
  endtask

  initial begin
    int seed;
    // R1: reset contents
    repeat (3) @(negedge clk);
    curReq = "R1";
    sweepRead(0, 63);
    check("copyDone reset", {15'h0, copyDone}, 16'h0);
    rstN = 1;
    tick();

    // R2: word mode writes and read-back
    curReq = "R2";
    for (int w = 0; w < WORDS; w++) hostWrite(0, w, 16'hA500 ^ 16'(w * 16'h0111));
    sweepRead(0, 63);
    hostAddr = 6'd3; #1 check("R2 word 3 literal", hostRdData, 16'hA500 ^ 16'h0333);

    // R10: transmit side still zero after edits
    curReq = "R10";
    sweepRead(0, 31);
    txIndex = 5'd3; #1 check("tx untouched by edit", txWord, 16'h0);

    // R5 and R7: copy and flag
    curReq = "R5";
    pulseCopy();
    txIndex = 5'd3; #1 check("R5 copied word 3", txWord, 16'hA500 ^ 16'h0333);
    check("R7 flag set", {15'h0, copyDone}, 16'h1);
    curReq = "R7";
    tick(); tick();
    check("R7 flag sticky", {15'h0, copyDone}, 16'h1);

    // R8: clearing read
    curReq = "R8";
    statusRd = 1; tick();
    check("R8 flag cleared", {15'h0, copyDone}, 16'h0);
    pulseCopy();
    statusRd = 1; blockStart = 1; tick();
    check("R8 copy beats clear", {15'h0, copyDone}, 16'h1);
    statusRd = 1; tick();

    // R3: byte mode lanes
    curReq = "R3";
    hostWrite(1, 10, 16'hFF5A);
    hostWrite(1, 11, 16'hEEC3);
    byteMode = 1; hostAddr = 6'd10; #1 check("R3 even byte", hostRdData, 16'h005A);
    byteMode = 0; hostAddr = 6'd5;  #1 check("R3 word view", hostRdData, 16'h5AC3);
    hostWrite(1, 47, 16'h0077);
    sweepRead(1, 63);

    // R4: gated writes
    curReq = "R4";
    powerDown = 1; hostWrite(0, 5, 16'h1234); powerDown = 0;
    clkPresent = 0; hostWrite(1, 10, 16'h0099); clkPresent = 1;
    byteMode = 0; hostAddr = 6'd5; #1 check("R4 word 5 kept", hostRdData, 16'h5AC3);
    sweepRead(0, 23);

    // R6: inhibit
    curReq = "R6";
    inhibitCopy = 1;
    pulseCopy(); pulseCopy();
    txIndex = 5'd5; #1 check("R6 tx word 5 old", txWord, 16'hA500 ^ 16'h0555);
    sweepRead(0, 31);
    inhibitCopy = 0;
    curReq = "R5";
    pulseCopy();
    txIndex = 5'd5; #1 check("R5 tx after release", txWord, 16'h5AC3);

    // R5: write and copy in the same cycle
    blockStart = 1; hostWrite(0, 7, 16'hBEEF);
    txIndex = 5'd7; #1 check("R5 collision tx old", txWord, 16'hA500 ^ 16'h0777);
    hostAddr = 6'd7; byteMode = 0; #1 check("R5 collision edit new", hostRdData, 16'hBEEF);

    // R9: out-of-range addresses
    curReq = "R9";
    for (int a = 24; a < 64; a++) hostWrite(0, a, 16'hDEAD);
    for (int a = 48; a < 64; a++) hostWrite(1, a, 16'h00AD);
    sweepRead(0, 63);
    sweepRead(1, 63);
    txIndex = 5'd30; #1 check("R9 tx index 30", txWord, 16'h0);

    // R11 with mixed pseudo-random traffic
    curReq = "R11";
    seed = 32'h1234_5678;
    for (int n = 0; n < 3000; n++) begin
      seed = seed ^ (seed << 13); seed = seed ^ (seed >>> 17); seed = seed ^ (seed << 5);
      hostWrEn    = seed[0];
      byteMode    = seed[1];
      hostAddr    = 6'(seed[7:2]);
      hostWrData  = seed[23:8];
      blockStart  = seed[26:24] == 3'd0;
      inhibitCopy = seed[29:27] == 3'd0;
      statusRd    = seed[30];
      powerDown   = seed[12:9] == 4'd0;
      clkPresent  = seed[16:13] != 4'd0;
      txIndex     = 5'(seed[31:27]);
      tick();
    end
    inhibitCopy = 0; powerDown = 0; clkPresent = 1;
    sweepRead(0, 63);
    sweepRead(1, 63);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule